// File: doc/BRIEF.md
# RGBW Color Generator with Dimming

This block sets the four 8-bit duty levels (red, green, blue, white) that drive a lamp's PWM stage. It can take the levels from two places. In direct mode it forwards a 32-bit RGBW word delivered by a serial receiver, untouched. In generated mode it ignores that word. Instead it walks a six-segment color wheel indexed by an 8-bit hue, adds a white component, and dims all four channels.

Dimming uses a variable right shift rather than a divider. This keeps the logic small, at the cost of coarse brightness steps: eight levels, each one half of the previous. White saturation does two things. It drives the white channel directly, and its top two bits also pull the RGB channels down by a shift.

All four outputs are registered. They follow any input change on the next clock edge. A received word is captured only while its valid strobe is high.

Top module: `rgbw_colorgen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives all four outputs to zero.
- R2: In direct mode (`gen_mode`=0), a word presented with `rx_valid`=1 appears on the outputs at the next clock edge. The word is split as red=[31:24], green=[23:16], blue=[15:8], white=[7:0].
- R3: While `rx_valid`=0, the received word input is ignored. In direct mode the outputs keep the last word accepted.
- R4: A word accepted while in generated mode is the one shown on return to direct mode.
- R5: In direct mode, `hue`, `white_sat` and `dim_shift` have no effect on the outputs.
- R6: In generated mode the received word has no effect on the outputs.
- R7: The hue wheel is computed from h6 = hue*6 (11 bits). The segment s = h6[10:8] and the ramp f = h6[7:0], with d = 255-f. The base (R,G,B) for each segment is:
  - s=0: (255,f,0)
  - s=1: (d,255,0)
  - s=2: (0,255,f)
  - s=3: (0,d,255)
  - s=4: (f,0,255)
  - s=5: (255,0,d)
- R8: In generated mode, each RGB base value is shifted right by `white_sat[7:6]`. The white channel is `white_sat`.
- R9: In generated mode, all four channels are then shifted right by `dim_shift` (0 to 7). A shift of 0 gives full brightness, and a shift of 7 leaves at most 1.
- R10: Outputs change exactly one clock edge after a change of mode, hue or settings, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_mode | input | 1 | 0 = direct pass-through, 1 = generated color |
| rx_word | input | 32 | Received RGBW word {R,G,B,W} |
| rx_valid | input | 1 | Capture strobe for rx_word |
| hue | input | 8 | Color wheel index |
| white_sat | input | 8 | White saturation level |
| dim_shift | input | 3 | Dimming right-shift amount |
| red_o | output | 8 | Red duty |
| grn_o | output | 8 | Green duty |
| blu_o | output | 8 | Blue duty |
| wht_o | output | 8 | White duty |

## Verification
The block has one internal state: the held received word. It also has a single output register stage, so any fault shows at the ports one edge after the stimulus.

A held word that is corrupted, or a word captured without its strobe, appears as soon as direct mode is selected while the strobe is low. This includes the first edge after a return from generated mode. A wrong segment decode or a wrong shift shows as a wrong level on the very next edge of the generated-mode vector that exercises it. The vectors therefore cover every segment, every saturation shift and the extreme dimming values.

// File: rtl/rgbw_colorgen.sv
module rgbw_colorgen #(
  parameter int CW = 8,
  parameter int SW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gen_mode,
  input  logic [4*CW-1:0] rx_word,
  input  logic            rx_valid,
  input  logic [CW-1:0]   hue,
  input  logic [CW-1:0]   white_sat,
  input  logic [SW-1:0]   dim_shift,
  output logic [CW-1:0]   red_o,
  output logic [CW-1:0]   grn_o,
  output logic [CW-1:0]   blu_o,
  output logic [CW-1:0]   wht_o
);
  localparam logic [CW-1:0] FULL = '1;

  logic [4*CW-1:0] held;
  logic [4*CW-1:0] direct;
  logic [CW+2:0]   h6;
  logic [CW-1:0]   up, dn, br, bg, bb;
  logic [1:0]      wsh;
  logic [4*CW-1:0] made;

  assign direct = rx_valid ? rx_word : held;
  assign h6     = {3'b000, hue} * (CW+3)'(6);
  assign up     = h6[CW-1:0];
  assign dn     = ~h6[CW-1:0];
  assign wsh    = white_sat[CW-1:CW-2];

  always_comb begin
    case (h6[CW+2:CW])
      3'd0:    {br, bg, bb} = {FULL, up, {CW{1'b0}}};
      3'd1:    {br, bg, bb} = {dn, FULL, {CW{1'b0}}};
      3'd2:    {br, bg, bb} = {{CW{1'b0}}, FULL, up};
      3'd3:    {br, bg, bb} = {{CW{1'b0}}, dn, FULL};
      3'd4:    {br, bg, bb} = {up, {CW{1'b0}}, FULL};
      default: {br, bg, bb} = {FULL, {CW{1'b0}}, dn};
    endcase
  end

  assign made = {(br >> wsh) >> dim_shift,
                 (bg >> wsh) >> dim_shift,
                 (bb >> wsh) >> dim_shift,
                 white_sat >> dim_shift};

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      {red_o, grn_o, blu_o, wht_o} <= '0;
    end else begin
      if (rx_valid) held <= rx_word;
      {red_o, grn_o, blu_o, wht_o} <= gen_mode ? made : direct;
    end
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (red_o == '0 && grn_o == '0 && blu_o == '0 && wht_o == '0));

  // R2
  direct_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!gen_mode && rx_valid) |=> ({red_o, grn_o, blu_o, wht_o} == $past(rx_word)));

  // R3
  direct_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(gen_mode) && !gen_mode && !rx_valid)
      |=> ($stable(red_o) && $stable(grn_o) && $stable(blu_o) && $stable(wht_o)));

  // R9
  deep_dim_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_mode && dim_shift == '1) |=> (red_o <= 1 && grn_o <= 1 && blu_o <= 1 && wht_o <= 1));

  // R7
  wheel_peak_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_mode && dim_shift == '0 && wsh == 2'd0)
      |=> (red_o == FULL || grn_o == FULL || blu_o == FULL));

  // R8
  white_full_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_mode && dim_shift == '0) |=> (wht_o == $past(white_sat)));
endmodule

// File: tb/rgbw_colorgen_test.sv
module rgbw_colorgen_test;
  logic clk = 0, rst = 1, gen_mode = 0, rx_valid = 0;
  logic [31:0] rx_word = '0;
  logic [7:0] hue = '0, white_sat = '0;
  logic [2:0] dim_shift = '0;
  logic [7:0] red_o, grn_o, blu_o, wht_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rgbw_colorgen uut (.clk, .rst, .gen_mode, .rx_word, .rx_valid, .hue,
                     .white_sat, .dim_shift, .red_o, .grn_o, .blu_o, .wht_o);

  // hue, white_sat, dim_shift, expected {R,G,B,W}  (R7, R8, R9)
  localparam logic [50:0] VEC [8] = '{
    {8'd0,   8'h00, 3'd0, 32'hFF000000},
    {8'd43,  8'h00, 3'd0, 32'hFDFF0000},
    {8'd128, 8'h00, 3'd0, 32'h00FFFF00},
    {8'd255, 8'h00, 3'd0, 32'hFF000500},
    {8'd20,  8'h80, 3'd0, {8'd63, 8'd30, 8'd0, 8'd128}},
    {8'd100, 8'hFF, 3'd1, {8'd0, 8'd15, 8'd5, 8'd127}},
    {8'd200, 8'h3F, 3'd3, {8'd22, 8'd0, 8'd31, 8'd7}},
    {8'd170, 8'h00, 3'd7, {8'd0, 8'd0, 8'd1, 8'd0}}
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [31:0] exp);
    checks++;
    if ({red_o, grn_o, blu_o, wht_o} !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, {red_o, grn_o, blu_o, wht_o}, exp);
    end
  endtask

  initial begin
    rx_word = 32'hA1B2C3D4; rx_valid = 1; hue = 8'd77; white_sat = 8'hC0; dim_shift = 3'd2;
    step(); step();
    check("R1 reset", 32'h0);
    @(negedge clk); rst = 0; rx_valid = 0;
    step();
    check("R3 no strobe after reset", 32'h0);

    @(negedge clk); rx_word = 32'h11223344; rx_valid = 1;
    step();
    check("R2 direct pass", 32'h11223344);
    @(negedge clk); rx_valid = 0; rx_word = 32'hDEADBEEF;
    step();
    check("R3 hold without strobe", 32'h11223344);
    @(negedge clk); hue = 8'd5; white_sat = 8'hFF; dim_shift = 3'd7;
    step();
    check("R5 settings ignored in direct", 32'h11223344);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      gen_mode = 1; {hue, white_sat, dim_shift} = VEC[i][50:32];
      step();
      check("R7/R8/R9 vector", VEC[i][31:0]);
    end

    @(negedge clk); hue = 8'd0; white_sat = 8'h00; dim_shift = 3'd0;
    rx_word = 32'h55667788; rx_valid = 1;
    step();
    check("R6 word ignored in generated", 32'hFF000000);
    @(negedge clk); rx_valid = 0; rx_word = 32'h99999999;
    hue = 8'd128;
    #5;
    check("R10 no early change", 32'hFF000000);
    step();
    check("R10 change after one edge", 32'h00FFFF00);
    @(negedge clk); gen_mode = 0;
    step();
    check("R4 word accepted in generated mode", 32'h55667788);

    @(negedge clk); rst = 1;
    step();
    check("R1 reset mid-run", 32'h0);
    @(negedge clk); rst = 0;
    step();
    check("R1 held word cleared", 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule